// File: doc/BRIEF.md
# Swept-Frequency DDS Master Oscillator

This block is a direct digital synthesis master oscillator whose frequency follows a repeating linear law. A one-cycle start pulse begins a new acceleration cycle. The tuning word is loaded with its start value and then climbs by a fixed signed step on every sample until a set number of samples has passed. After that it stays at its end value until the next start pulse. Each output channel has its own phase accumulator. Channel 0 is the fundamental, and channel k advances by (k+1) times the tuning word, so channel 1 runs at the second harmonic. Each channel drives a sine/cosine pair taken from one quarter-wave table.

On every sample, the tuning word that the accumulators just added is published on a broadcast bus together with a valid strobe. Slave local oscillators that add the same word on the same strobe stay phase-locked to the master, with no per-slave frequency law. The `sample_en` input sets the sample rate: nothing advances on a clock edge where it is low. With the default parameters and a 120 MS/s sample rate, the fundamental sweeps from about 1.3 MHz to 3.1 MHz over a 1,200,000-sample (10 ms) window. A new window starts with each 50 Hz start pulse.

Top module: `sweep_dds_osc`

## Requirements
- R1: After reset, `bc_valid` is 0 and every sine and cosine output is 0. The tuning word is `TW_START`, and it stays there on every sample until the first `cycle_start`.
- R2: A `cycle_start` pulse loads `TW_START`. That word is published on the first sample edge after the pulse edge, whatever `sample_en` was on the pulse edge.
- R3: During the window, the word published on each sample is `TW_STEP` larger (modulo 2^TW_W) than the word published on the sample before.
- R4: After `WIN_LEN` window samples, the word stays at `TW_START + WIN_LEN*TW_STEP`. The first `WIN_LEN+1` samples after a start pulse publish `TW_START + j*TW_STEP` for j = 0..WIN_LEN, and every later sample publishes the end word.
- R5: A `cycle_start` in the middle of a sweep restarts it: the next sample publishes `TW_START` and the ramp begins again from there.
- R6: On an edge where `sample_en` is 0 and `cycle_start` is 0, the tuning word, the sweep position and every phase hold, and `bc_valid` is 0. When sampling resumes, the first published word is the one that was pending.
- R7: On each sample edge, the phase of channel k (TW_W bits, reset to 0) increases by (k+1) times the current tuning word, modulo 2^TW_W.
- R8: `bc_valid` is 1 on exactly the edges where the accumulators advance, and `bc_tw` then holds the increment that channel 0 added on that edge.
- R9: Each channel registers its sine and cosine one clock after its phase. Let p be the top LUT_AW+2 phase bits, N = 2^(LUT_AW+2) and A = 2^(AMP_W-1)-1. The sine is round(A·sin(2π(p+0.5)/N)) and the cosine is round(A·cos(2π(p+0.5)/N)), both signed. Channel k occupies bits [k·AMP_W +: AMP_W] of each bus.
- R10: The channel 1 phase is always exactly twice the channel 0 phase modulo 2^TW_W, so its waveform runs at the second harmonic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Sample-rate enable; the oscillator advances on edges where it is 1 |
| cycle_start | input | 1 | One-cycle pulse that starts (or restarts) a sweep |
| bc_tw | output | TW_W (32) | Broadcast tuning word, the increment used on the current sample |
| bc_valid | output | 1 | Strobe that marks a published sample |
| sin_bus | output | NUM_CH*AMP_W (24) | Signed sine outputs, channel k at [k*AMP_W +: AMP_W] |
| cos_bus | output | NUM_CH*AMP_W (24) | Signed cosine outputs, channel k at [k*AMP_W +: AMP_W] |

## Verification
The bench tests the reload boundary. A design that published `TW_START` one sample late, or stepped once on the pulse, would put the whole ramp off by one word. It runs the window to exactly `WIN_LEN+1` samples after a start pulse. That catches a counter that stops one step early or short, or that keeps ramping past the end word. It restarts a sweep partway through and inserts gaps in `sample_en` during a ramp, to expose a counter that is not cleared and a ramp or accumulator that advances without a sample. A running reference compares both channels' waveforms and every broadcast word cycle by cycle. This catches quadrant folding errors, a swapped sine and cosine, and a harmonic channel that adds the wrong multiple.

// File: rtl/sweep_dds_pkg.sv
// Shared types and constant functions for the swept DDS oscillator.
// Assumes only that callers evaluate the functions at elaboration time.
package sweep_dds_pkg;

    // Quadrant index taken from the two top phase bits.
    typedef logic [1:0] quadrant_t;

    // Sine by a series expansion, used only to compute table constants.
    function automatic real series_sine(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int n = 1; n < 10; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // One quarter-wave sample at the midpoint of slot idx, scaled to amp.
    function automatic int quarter_sample(input int idx, input int qlen, input int amp);
        real ang;
        ang = 3.14159265358979 * (real'(idx) + 0.5) / (2.0 * real'(qlen));
        return $rtoi(real'(amp) * series_sine(ang) + 0.5);
    endfunction

endpackage

// File: rtl/sweep_sequencer.sv
// Frequency-law sequencer: keeps the tuning word and the sweep position.
// A start pulse loads TW_START and clears the position. Each sample inside
// the window adds TW_STEP, and past WIN_LEN samples the word holds.
// Assumes cycle_start is a one-clock pulse in the clk domain.
module sweep_sequencer #(
    parameter int unsigned       TW_W     = 32,
    parameter int unsigned       WIN_LEN  = 1200000,
    parameter logic [TW_W-1:0]   TW_START = 32'd46528812,
    parameter logic [TW_W-1:0]   TW_STEP  = 32'd54
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_en,
    input  logic            cycle_start,
    output logic [TW_W-1:0] tw
);
    localparam int unsigned CNT_W = $clog2(WIN_LEN + 1);

    logic [CNT_W-1:0] pos;
    logic             in_window;

    // The sweep is live while the position is short of the window length.
    assign in_window = (pos < CNT_W'(WIN_LEN));

    // Reload on a start pulse, otherwise step once per sample in the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= CNT_W'(WIN_LEN);
            tw  <= TW_START;
        end else if (cycle_start) begin
            pos <= '0;
            tw  <= TW_START;
        end else if (sample_en && in_window) begin
            pos <= pos + CNT_W'(1);
            tw  <= tw + TW_STEP;
        end
    end

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> (tw == TW_START));

    // R3
    ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cycle_start && sample_en && in_window) |=> ((tw - $past(tw)) == TW_STEP));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cycle_start && !in_window) |=> $stable(tw));

    // R6
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cycle_start && !sample_en) |=> ($stable(tw) && $stable(pos)));

endmodule

// File: rtl/phase_accum.sv
// Phase accumulator bank and increment broadcast. Channel k adds (k+1)
// times the tuning word on each sample. The word used is published with
// a strobe on the same edge. Assumes the caller holds tw steady between edges.
module phase_accum #(
    parameter int unsigned TW_W   = 32,
    parameter int unsigned NUM_CH = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sample_en,
    input  logic [TW_W-1:0]        tw,
    output logic [NUM_CH*TW_W-1:0] phase_bus,
    output logic [TW_W-1:0]        bc_tw,
    output logic                   bc_valid
);
    // Publish the increment and strobe on the edge the phases move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc_tw    <= '0;
            bc_valid <= 1'b0;
        end else begin
            bc_valid <= sample_en;
            if (sample_en) begin
                bc_tw <= tw;
            end
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam logic [TW_W-1:0] MULT = TW_W'(k + 1);
        logic [TW_W-1:0] inc;
        logic [TW_W-1:0] ph;

        assign inc = tw * MULT;
        assign phase_bus[k*TW_W +: TW_W] = ph;

        // Advance this channel's phase once per sample.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ph <= '0;
            end else if (sample_en) begin
                ph <= ph + inc;
            end
        end

        if (k > 0) begin : g_harm
            // R10
            harm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
                phase_bus[k*TW_W +: TW_W] == TW_W'(phase_bus[TW_W-1:0] * MULT));
        end
    end

endmodule

// File: rtl/quarter_sincos.sv
// Sine/cosine generator built on one quarter-wave table. The top LUT_AW+2
// phase bits pick a quadrant and a slot; mirroring and negation fold the
// quarter into a full wave. The cosine reads a quarter turn ahead.
// Outputs are registered, one clock behind the phase.
module quarter_sincos #(
    parameter int unsigned PH_W   = 32,
    parameter int unsigned LUT_AW = 6,
    parameter int unsigned AMP_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PH_W-1:0]         phase,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);
    import sweep_dds_pkg::*;

    localparam int unsigned IW   = LUT_AW + 2;
    localparam int unsigned QLEN = 1 << LUT_AW;
    localparam int          AMAX = (1 << (AMP_W - 1)) - 1;

    logic [AMP_W-1:0] qtab [QLEN];
    logic [IW-1:0]    pidx;

    for (genvar i = 0; i < QLEN; i++) begin : g_tab
        localparam int VAL = quarter_sample(i, QLEN, AMAX);
        assign qtab[i] = AMP_W'(VAL);
    end

    assign pidx = phase[PH_W-1 -: IW];

    // Fold a full-wave index onto the quarter table.
    function automatic logic signed [AMP_W-1:0] wave(input logic [IW-1:0] p);
        quadrant_t               q;
        logic [LUT_AW-1:0]       a;
        logic signed [AMP_W-1:0] m;
        q = p[IW-1 -: 2];
        a = q[0] ? ~p[LUT_AW-1:0] : p[LUT_AW-1:0];
        m = signed'(qtab[a]);
        return q[1] ? -m : m;
    endfunction

    // Register both waveforms from the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_o <= '0;
            cos_o <= '0;
        end else begin
            sin_o <= wave(pidx);
            cos_o <= wave(pidx + IW'(QLEN));
        end
    end

    // R9
    amp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sin_o) <= AMAX) && (int'(sin_o) >= -AMAX) &&
        (int'(cos_o) <= AMAX) && (int'(cos_o) >= -AMAX));

endmodule

// File: rtl/sweep_dds_osc.sv
// Swept-frequency DDS master oscillator top. It joins the frequency-law
// sequencer, the phase accumulator bank with its broadcast, and one
// sine/cosine generator per channel. Assumes sample_en gives the sample
// rate and cycle_start is a one-clock pulse.
module sweep_dds_osc #(
    parameter int unsigned     TW_W     = 32,
    parameter int unsigned     WIN_LEN  = 1200000,
    parameter logic [TW_W-1:0] TW_START = 32'd46528812,
    parameter logic [TW_W-1:0] TW_STEP  = 32'd54,
    parameter int unsigned     NUM_CH   = 2,
    parameter int unsigned     LUT_AW   = 6,
    parameter int unsigned     AMP_W    = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic                    cycle_start,
    output logic [TW_W-1:0]         bc_tw,
    output logic                    bc_valid,
    output logic [NUM_CH*AMP_W-1:0] sin_bus,
    output logic [NUM_CH*AMP_W-1:0] cos_bus
);
    logic [TW_W-1:0]        tw;
    logic [NUM_CH*TW_W-1:0] phase_bus;

    sweep_sequencer #(
        .TW_W(TW_W), .WIN_LEN(WIN_LEN), .TW_START(TW_START), .TW_STEP(TW_STEP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
        .cycle_start(cycle_start), .tw(tw)
    );

    phase_accum #(.TW_W(TW_W), .NUM_CH(NUM_CH)) u_acc (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .tw(tw),
        .phase_bus(phase_bus), .bc_tw(bc_tw), .bc_valid(bc_valid)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_wave
        logic signed [AMP_W-1:0] s;
        logic signed [AMP_W-1:0] c;

        quarter_sincos #(.PH_W(TW_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_sc (
            .clk(clk), .rst_n(rst_n), .phase(phase_bus[k*TW_W +: TW_W]),
            .sin_o(s), .cos_o(c)
        );

        assign sin_bus[k*AMP_W +: AMP_W] = s;
        assign cos_bus[k*AMP_W +: AMP_W] = c;
    end

    // R8
    bcast_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |-> (phase_bus[TW_W-1:0] == TW_W'($past(phase_bus[TW_W-1:0]) + bc_tw)));

    // R6
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bc_valid |-> $stable(phase_bus));

endmodule

// File: tb/tb_sweep_dds_osc.sv
// Directed bench for sweep_dds_osc: one task per scenario, plus a running
// reference that checks the waveforms and broadcast on every clock.
module tb_sweep_dds_osc;
    localparam int unsigned     TW_W     = 32;
    localparam int unsigned     WIN_LEN  = 16;
    localparam logic [31:0]     TW_START = 32'h0123_4567;
    localparam logic [31:0]     TW_STEP  = 32'h0011_0000;
    localparam int unsigned     NUM_CH   = 2;
    localparam int unsigned     LUT_AW   = 6;
    localparam int unsigned     AMP_W    = 12;
    localparam int unsigned     IW       = LUT_AW + 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    sample_en = 1'b0;
    logic                    cycle_start = 1'b0;
    logic [TW_W-1:0]         bc_tw;
    logic                    bc_valid;
    logic [NUM_CH*AMP_W-1:0] sin_bus;
    logic [NUM_CH*AMP_W-1:0] cos_bus;

    int tests = 0;
    int fails = 0;
    bit ref_on = 1'b0;

    sweep_dds_osc #(
        .TW_W(TW_W), .WIN_LEN(WIN_LEN), .TW_START(TW_START), .TW_STEP(TW_STEP),
        .NUM_CH(NUM_CH), .LUT_AW(LUT_AW), .AMP_W(AMP_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .cycle_start(cycle_start),
        .bc_tw(bc_tw), .bc_valid(bc_valid), .sin_bus(sin_bus), .cos_bus(cos_bus)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected waveform value from the requirement formula.
    function automatic int exp_wave(input logic [TW_W-1:0] ph, input bit cosine);
        real a;
        real ang;
        real v;
        a   = real'((1 << (AMP_W - 1)) - 1);
        ang = 2.0 * 3.14159265358979 * (real'(ph[TW_W-1 -: IW]) + 0.5) / real'(1 << IW);
        v   = cosine ? a * $cos(ang) : a * $sin(ang);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int lane(input logic [NUM_CH*AMP_W-1:0] bus, input int k);
        logic signed [AMP_W-1:0] x;
        x = bus[k*AMP_W +: AMP_W];
        return int'(x);
    endfunction

    // Running reference built from the requirements.
    logic [TW_W-1:0] m_tw;
    int              m_pos;
    logic [TW_W-1:0] m_ph [NUM_CH];
    logic            m_bv;
    logic [TW_W-1:0] m_btw;
    int              m_sin [NUM_CH];
    int              m_cos [NUM_CH];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tw  = TW_START;
            m_pos = WIN_LEN;
            m_bv  = 1'b0;
            m_btw = '0;
            for (int k = 0; k < NUM_CH; k++) begin
                m_ph[k]  = '0;
                m_sin[k] = 0;
                m_cos[k] = 0;
            end
        end else begin
            for (int k = 0; k < NUM_CH; k++) begin
                m_sin[k] = exp_wave(m_ph[k], 1'b0);
                m_cos[k] = exp_wave(m_ph[k], 1'b1);
            end
            m_bv = sample_en;
            if (sample_en) begin
                m_btw = m_tw;
                for (int k = 0; k < NUM_CH; k++) begin
                    m_ph[k] = m_ph[k] + TW_W'((k + 1) * m_tw);
                end
            end
            if (cycle_start) begin
                m_tw  = TW_START;
                m_pos = 0;
            end else if (sample_en && m_pos < WIN_LEN) begin
                m_tw  = m_tw + TW_STEP;
                m_pos = m_pos + 1;
            end
        end
    end

    // Compare the reference every clock: R7 R8 R9 R10.
    always @(negedge clk) begin
        if (ref_on) begin
            check("R8", "bc_valid", longint'(bc_valid), longint'(m_bv));
            if (m_bv) check("R8", "bc_tw", longint'(bc_tw), longint'(m_btw));
            for (int k = 0; k < NUM_CH; k++) begin
                check(k == 0 ? "R7 R9" : "R10 R9", "sin", lane(sin_bus, k), m_sin[k]);
                check(k == 0 ? "R7 R9" : "R10 R9", "cos", lane(cos_bus, k), m_cos[k]);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start();
        cycle_start = 1'b1;
        step();
        cycle_start = 1'b0;
    endtask

    // R1: reset values, then the start word holds before any trigger.
    task automatic t_reset();
        rst_n = 1'b0;
        sample_en = 1'b0;
        cycle_start = 1'b0;
        repeat (3) step();
        check("R1", "bc_valid after reset", longint'(bc_valid), 0);
        check("R1", "sin0 after reset", lane(sin_bus, 0), 0);
        check("R1", "cos1 after reset", lane(cos_bus, 1), 0);
        rst_n = 1'b1;
        ref_on = 1'b1;
        sample_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R1", "word before first trigger", longint'(bc_tw), longint'(TW_START));
        end
    endtask

    // R2 R3 R4: full ramp, then hold at the end word.
    task automatic t_full_sweep();
        sample_en = 1'b1;
        pulse_start();
        for (int j = 0; j <= WIN_LEN; j++) begin
            step();
            if (j == 0) check("R2", "first word after start", longint'(bc_tw), longint'(TW_START));
            else check("R3", "ramp word", longint'(bc_tw), longint'(TW_W'(TW_START + j * TW_STEP)));
        end
        for (int i = 0; i < 5; i++) begin
            step();
            check("R4", "end word held", longint'(bc_tw), longint'(TW_W'(TW_START + WIN_LEN * TW_STEP)));
        end
    endtask

    // R5: restart partway through a sweep.
    task automatic t_restart();
        sample_en = 1'b1;
        pulse_start();
        repeat (6) step();
        pulse_start();
        step();
        check("R5", "restart word", longint'(bc_tw), longint'(TW_START));
        step();
        check("R5", "ramp after restart", longint'(bc_tw), longint'(TW_W'(TW_START + TW_STEP)));
    endtask

    // R6: a gap in sample_en freezes the ramp and the waveforms.
    task automatic t_gap();
        logic [NUM_CH*AMP_W-1:0] s_hold;
        sample_en = 1'b1;
        pulse_start();
        repeat (3) step();
        sample_en = 1'b0;
        step();
        s_hold = sin_bus;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R6", "no strobe in gap", longint'(bc_valid), 0);
            check("R6", "waveform frozen", longint'(sin_bus), longint'(s_hold));
        end
        sample_en = 1'b1;
        step();
        check("R6", "resumed word", longint'(bc_tw), longint'(TW_W'(TW_START + 3 * TW_STEP)));
    endtask

    // R7 R9 R10: irregular sample pattern through sweep and hold.
    task automatic t_pattern();
        pulse_start();
        for (int i = 0; i < 300; i++) begin
            sample_en = (i % 3 != 1);
            step();
        end
        sample_en = 1'b1;
        repeat (200) step();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_full_sweep();
        t_restart();
        t_gap();
        t_pattern();
        ref_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule